// File: doc/BRIEF.md
# Character Display Power-On Sequencer

This block brings a character display controller of the common two-row, 4-bit-bus kind from power-up to a usable, blank state without help from software. Right after reset it holds every interface line as a driven output at 0 and waits out the supply settling time. While the controller is still in its default 8-bit state, it clocks in three bare nibbles. It then pauses briefly and switches to full byte transfers. Each byte is sent as two nibbles, high half first, and is preceded by status reads that repeat until the busy flag is clear.

The byte phase sets the interface format (4-bit, two rows, 5x8 font) and turns the display on. It then writes a row of space characters starting at the first-row address and another starting at the second-row address. When the last fill character has been strobed in, `ready` goes high and the display bus stays quiet until the next reset. All waits and strobe widths are parameters given in clock cycles, so a bench can shorten them.

Top module: `lcd_pwr_init`

## Requirements
- R1: While reset is asserted, `lcd_rs`, `lcd_rw`, `lcd_en` and `lcd_db_out` are 0, `lcd_db_oe` is 1 (bus driven) and `ready` is 0.
- R2: The first rising edge of `lcd_en` comes no earlier than POR_WAIT_CYC clock cycles after reset is released.
- R3: The first three enable pulses are single-nibble writes (`lcd_rs`=0, `lcd_rw`=0) carrying 0x2, 0x2 and 0x8 on `lcd_db_out`, in that order.
- R4: Between the falling edge of the third enable pulse and the next rising edge at least SETTLE_CYC cycles pass.
- R5: Every byte write comes after a status read (`lcd_rs`=0, `lcd_rw`=1) whose first nibble had bit 3 (the busy flag, DB7) equal to 0. A status read that returns busy=1 is followed by another status read, never by a write.
- R6: Every byte transfer, read or write, is exactly two enable pulses: upper nibble first, then lower nibble.
- R7: The written bytes are, in order: command 0x28, command 0x0C, command 0x80|ROW0_ADDR, ROW_LEN data bytes FILL_CHAR, command 0x80|ROW1_ADDR, and ROW_LEN data bytes FILL_CHAR. Commands use `lcd_rs`=0 and data uses `lcd_rs`=1. With default parameters that is 36 bytes.
- R8: `ready` stays 0 through every enable pulse of the sequence. It rises within LOW_CYC+4 cycles after the last fill nibble's enable falls, then stays 1 with `lcd_en` held at 0 until reset.
- R9: Every enable pulse is high for exactly HIGH_CYC cycles. Every gap between pulses is at least LOW_CYC cycles. `lcd_rs`, `lcd_rw` and, on writes, `lcd_db_out` hold steady while `lcd_en` is high.
- R10: While `lcd_en` is high, `lcd_db_oe` is the inverse of `lcd_rw`: the bus is released on reads and driven on writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcd_db_in | input | 4 | Upper data bus nibble as read from the display |
| lcd_rs | output | 1 | Register select: 0 command/status, 1 data |
| lcd_rw | output | 1 | Direction: 1 read, 0 write |
| lcd_en | output | 1 | Enable strobe |
| lcd_db_out | output | 4 | Upper data bus nibble driven to the display |
| lcd_db_oe | output | 1 | Data bus output enable |
| ready | output | 1 | Sequence complete |

## Verification
Two decisions can land in the same cycle, and both are exercised. The first is the end of a status read together with the choice between polling again and writing. The bench model returns a busy count for each byte that is drawn at random, with directed cases of zero (clear on the very first poll) and a long run of busy replies. It then checks that no write follows a poll whose busy bit was set. The second is the final fill nibble's completion together with the rise of `ready`. The bench confirms that `ready` is low at every enable edge, rises within a bounded window after the last one, and is followed by a bus that stays silent.

// File: rtl/lcd_init_pkg.sv
`timescale 1ns/1ps
package lcd_init_pkg;

  localparam logic [7:0] CMD_FUNC_4B_2ROW = 8'h28;
  localparam logic [7:0] CMD_DISPLAY_ON   = 8'h0C;
  localparam logic [7:0] CMD_SET_DDRAM    = 8'h80;
  localparam int unsigned BUSY_BIT        = 7;

  typedef enum logic [2:0] {
    ST_POR_ARM, ST_POR_WAIT, ST_RAW, ST_SET_ARM,
    ST_SET_WAIT, ST_POLL, ST_WRITE, ST_READY
  } seq_st_t;

  typedef enum logic [1:0] {NB_IDLE, NB_SETUP, NB_HIGH, NB_LOW} nib_st_t;

  typedef enum logic [2:0] {XF_IDLE, XF_HI, XF_HI_WAIT, XF_LO, XF_LO_WAIT} xf_st_t;

  typedef struct packed {
    logic       rs;
    logic [7:0] code;
  } lcd_op_t;

  // nibbles clocked in while the controller still runs an 8-bit bus
  function automatic logic [3:0] raw_nib(input logic [1:0] idx);
    return (idx == 2'd2) ? 4'h8 : 4'h2;
  endfunction

  function automatic int unsigned op_count(input int unsigned row_len);
    return 4 + 2 * row_len;
  endfunction

  function automatic logic [3:0] pick_half(input logic [7:0] b, input logic lo);
    return lo ? b[3:0] : b[7:4];
  endfunction

  // byte operation number idx of the post-raw phase
  function automatic lcd_op_t init_op(input int unsigned idx,
                                      input int unsigned row_len,
                                      input logic [6:0]  row0,
                                      input logic [6:0]  row1,
                                      input logic [7:0]  fill);
    lcd_op_t op;
    op.rs   = 1'b0;
    op.code = fill;
    if (idx == 0)                op.code = CMD_FUNC_4B_2ROW;
    else if (idx == 1)           op.code = CMD_DISPLAY_ON;
    else if (idx == 2)           op.code = CMD_SET_DDRAM | {1'b0, row0};
    else if (idx == 3 + row_len) op.code = CMD_SET_DDRAM | {1'b0, row1};
    else                         op.rs   = 1'b1;
    return op;
  endfunction

endpackage

// File: rtl/lcd_wait_timer.sv
`timescale 1ns/1ps
module lcd_wait_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= len;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0) && !load;

endmodule

// File: rtl/lcd_nibble_strobe.sv
`timescale 1ns/1ps
module lcd_nibble_strobe
  import lcd_init_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 10,
  parameter int unsigned HIGH_CYC  = 60,
  parameter int unsigned LOW_CYC   = 70
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rs_in,
  input  logic       rw_in,
  input  logic [3:0] nib_in,
  input  logic [3:0] db_in,
  output logic       done,
  output logic [3:0] rd_nib,
  output logic       pin_rs,
  output logic       pin_rw,
  output logic       pin_en,
  output logic [3:0] pin_db,
  output logic       pin_oe
);

  localparam int unsigned M1 = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
  localparam int unsigned MX = (M1 > LOW_CYC) ? M1 : LOW_CYC;
  localparam int unsigned PW = $clog2(MX + 1);
  localparam logic [PW-1:0] SETUP_L = PW'(SETUP_CYC - 1);
  localparam logic [PW-1:0] HIGH_L  = PW'(HIGH_CYC - 1);
  localparam logic [PW-1:0] LOW_L   = PW'(LOW_CYC - 1);

  nib_st_t       st;
  logic [PW-1:0] ph_cnt;
  logic [PW-1:0] ph_last;
  logic          ph_end;
  logic          rs_q, rw_q;
  logic [3:0]    nib_q;

  always_comb begin
    case (st)
      NB_SETUP: ph_last = SETUP_L;
      NB_HIGH:  ph_last = HIGH_L;
      default:  ph_last = LOW_L;
    endcase
  end
  assign ph_end = (ph_cnt == ph_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= NB_IDLE;
      ph_cnt <= '0;
      rs_q   <= 1'b0;
      rw_q   <= 1'b0;
      nib_q  <= 4'h0;
      rd_nib <= 4'h0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        NB_IDLE: if (start) begin
          rs_q   <= rs_in;
          rw_q   <= rw_in;
          nib_q  <= rw_in ? 4'h0 : nib_in;
          ph_cnt <= '0;
          st     <= NB_SETUP;
        end
        NB_SETUP: if (ph_end) begin
          ph_cnt <= '0;
          st     <= NB_HIGH;
        end else ph_cnt <= ph_cnt + 1'b1;
        NB_HIGH: if (ph_end) begin
          rd_nib <= db_in;
          ph_cnt <= '0;
          st     <= NB_LOW;
        end else ph_cnt <= ph_cnt + 1'b1;
        default: if (ph_end) begin
          ph_cnt <= '0;
          done   <= 1'b1;
          st     <= NB_IDLE;
        end else ph_cnt <= ph_cnt + 1'b1;
      endcase
    end
  end

  assign pin_rs = rs_q;
  assign pin_rw = rw_q;
  assign pin_db = nib_q;
  assign pin_oe = !rw_q;
  assign pin_en = (st == NB_HIGH);

  // R9: control and write data hold while the strobe is high
  a_r9_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en && $past(pin_en)) |-> ($stable(pin_rs) && $stable(pin_rw) && $stable(pin_db)));

  // R9: a new request never cuts into a running strobe cycle
  a_r9_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st == NB_IDLE));

endmodule

// File: rtl/lcd_byte_xfer.sv
`timescale 1ns/1ps
module lcd_byte_xfer
  import lcd_init_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rs_in,
  input  logic       rw_in,
  input  logic [7:0] byte_in,
  output logic       done,
  output logic [7:0] rd_byte,
  output logic       nb_start,
  output logic       nb_rs,
  output logic       nb_rw,
  output logic [3:0] nb_nib,
  input  logic       nb_done,
  input  logic [3:0] nb_rd
);

  xf_st_t     st;
  logic       rs_q, rw_q;
  logic [7:0] byte_q;
  logic       lo_half;

  assign lo_half  = (st == XF_LO) || (st == XF_LO_WAIT);
  assign nb_start = (st == XF_HI) || (st == XF_LO);
  assign nb_rs    = rs_q;
  assign nb_rw    = rw_q;
  assign nb_nib   = pick_half(byte_q, lo_half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= XF_IDLE;
      rs_q    <= 1'b0;
      rw_q    <= 1'b0;
      byte_q  <= 8'h00;
      rd_byte <= 8'h00;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        XF_IDLE: if (start) begin
          rs_q   <= rs_in;
          rw_q   <= rw_in;
          byte_q <= byte_in;
          st     <= XF_HI;
        end
        XF_HI:      st <= XF_HI_WAIT;
        XF_HI_WAIT: if (nb_done) begin
          rd_byte[7:4] <= nb_rd;
          st           <= XF_LO;
        end
        XF_LO:      st <= XF_LO_WAIT;
        default: if (nb_done) begin
          rd_byte[3:0] <= nb_rd;
          done         <= 1'b1;
          st           <= XF_IDLE;
        end
      endcase
    end
  end

  // R6: a byte ends only after its lower half has been strobed
  a_r6_done_after_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(st) == XF_LO_WAIT));

endmodule

// File: rtl/lcd_pwr_init.sv
`timescale 1ns/1ps
module lcd_pwr_init
  import lcd_init_pkg::*;
#(
  parameter int unsigned POR_WAIT_CYC = 8000000,
  parameter int unsigned SETTLE_CYC   = 10000,
  parameter int unsigned SETUP_CYC    = 10,
  parameter int unsigned HIGH_CYC     = 60,
  parameter int unsigned LOW_CYC      = 70,
  parameter int unsigned ROW_LEN      = 16,
  parameter logic [6:0]  ROW0_ADDR    = 7'h00,
  parameter logic [6:0]  ROW1_ADDR    = 7'h40,
  parameter logic [7:0]  FILL_CHAR    = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] lcd_db_in,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_en,
  output logic [3:0] lcd_db_out,
  output logic       lcd_db_oe,
  output logic       ready
);

  localparam int unsigned TMAX = (POR_WAIT_CYC > SETTLE_CYC) ? POR_WAIT_CYC : SETTLE_CYC;
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam int unsigned NOPS = op_count(ROW_LEN);
  localparam int unsigned SW   = $clog2(NOPS + 1);

  seq_st_t    st;
  logic [1:0] raw_idx;
  logic       raw_pend, xf_pend, poll_ok;
  logic [SW-1:0] step;

  // named internal events
  logic raw_phase, raw_start, raw_last, raw_done;
  logic xf_start, xf_done, poll_done, poll_clear, write_done, step_last;
  logic tmr_load, tmr_expired;
  logic [TW-1:0] tmr_len;
  lcd_op_t cur_op;

  // engine and transactor wires
  logic       eng_start, eng_rs, eng_rw, eng_done;
  logic [3:0] eng_nib, eng_rd;
  logic       xf_nb_start, xf_nb_rs, xf_nb_rw;
  logic [3:0] xf_nb_nib;
  logic [7:0] xf_rd;

  assign raw_phase  = (st == ST_RAW);
  assign raw_start  = raw_phase && !raw_pend;
  assign raw_done   = raw_phase && eng_done;
  assign raw_last   = (raw_idx == 2'd2);
  assign xf_start   = ((st == ST_POLL) || (st == ST_WRITE)) && !xf_pend;
  assign poll_done  = (st == ST_POLL) && xf_done;
  assign poll_clear = poll_done && !xf_rd[BUSY_BIT];
  assign write_done = (st == ST_WRITE) && xf_done;
  assign step_last  = (step == SW'(NOPS - 1));
  assign cur_op     = init_op(32'(step), ROW_LEN, ROW0_ADDR, ROW1_ADDR, FILL_CHAR);
  assign tmr_load   = (st == ST_POR_ARM) || (st == ST_SET_ARM);
  assign tmr_len    = (st == ST_POR_ARM) ? TW'(POR_WAIT_CYC) : TW'(SETTLE_CYC);
  assign ready      = (st == ST_READY);

  assign eng_start = raw_start | xf_nb_start;
  assign eng_rs    = raw_phase ? 1'b0 : xf_nb_rs;
  assign eng_rw    = raw_phase ? 1'b0 : xf_nb_rw;
  assign eng_nib   = raw_phase ? raw_nib(raw_idx) : xf_nb_nib;

  lcd_wait_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len), .expired(tmr_expired)
  );

  lcd_nibble_strobe #(.SETUP_CYC(SETUP_CYC), .HIGH_CYC(HIGH_CYC), .LOW_CYC(LOW_CYC)) u_strobe (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .rs_in(eng_rs), .rw_in(eng_rw),
    .nib_in(eng_nib), .db_in(lcd_db_in), .done(eng_done), .rd_nib(eng_rd),
    .pin_rs(lcd_rs), .pin_rw(lcd_rw), .pin_en(lcd_en), .pin_db(lcd_db_out), .pin_oe(lcd_db_oe)
  );

  lcd_byte_xfer u_xfer (
    .clk(clk), .rst_n(rst_n), .start(xf_start), .rs_in(cur_op.rs && (st == ST_WRITE)),
    .rw_in(st == ST_POLL), .byte_in(cur_op.code), .done(xf_done), .rd_byte(xf_rd),
    .nb_start(xf_nb_start), .nb_rs(xf_nb_rs), .nb_rw(xf_nb_rw), .nb_nib(xf_nb_nib),
    .nb_done(eng_done), .nb_rd(eng_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_POR_ARM;
      raw_idx  <= 2'd0;
      raw_pend <= 1'b0;
      xf_pend  <= 1'b0;
      poll_ok  <= 1'b0;
      step     <= '0;
    end else begin
      if (raw_start) raw_pend <= 1'b1;
      if (xf_start)  xf_pend  <= 1'b1;
      if (xf_done)   xf_pend  <= 1'b0;
      if (poll_clear) poll_ok <= 1'b1;
      if (write_done) poll_ok <= 1'b0;
      case (st)
        ST_POR_ARM:  st <= ST_POR_WAIT;
        ST_POR_WAIT: if (tmr_expired) st <= ST_RAW;
        ST_RAW: if (raw_done) begin
          raw_pend <= 1'b0;
          if (raw_last) st <= ST_SET_ARM;
          else          raw_idx <= raw_idx + 2'd1;
        end
        ST_SET_ARM:  st <= ST_SET_WAIT;
        ST_SET_WAIT: if (tmr_expired) st <= ST_POLL;
        ST_POLL:     if (poll_clear) st <= ST_WRITE;
        ST_WRITE: if (write_done) begin
          if (step_last) st <= ST_READY;
          else begin
            step <= step + 1'b1;
            st   <= ST_POLL;
          end
        end
        default: st <= ST_READY;
      endcase
    end
  end

  // R8: once complete, stays complete
  a_r8_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R8: no strobe after completion
  a_r8_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !lcd_en);

  // R2: nothing strobed during the supply wait
  a_r2_quiet_in_por: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_POR_ARM) || (st == ST_POR_WAIT)) |-> !lcd_en);

  // R5: a byte write is launched only after a poll saw the busy flag clear
  a_r5_write_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_WRITE) && xf_start) |-> poll_ok);

  // R5: every strobe of a poll is a read
  a_r5_poll_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en && (st == ST_POLL)) |-> (lcd_rw && !lcd_rs));

  // R5: the returned status is fully defined when judged
  a_r5_status_defined: assert property (@(posedge clk) disable iff (!rst_n)
    poll_done |-> !$isunknown(xf_rd));

endmodule

// File: tb/lcd_pwr_init_test.sv
`timescale 1ns/1ps
module lcd_pwr_init_test;

  localparam int POR    = 300;
  localparam int SETTLE = 40;
  localparam int SETUP  = 2;
  localparam int HIGH   = 3;
  localparam int LOW    = 4;
  localparam int L      = 16;
  localparam int NOPS   = 4 + 2 * L;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] db_in;
  logic lcd_rs, lcd_rw, lcd_en, lcd_db_oe, ready;
  logic [3:0] lcd_db_out;

  lcd_pwr_init #(
    .POR_WAIT_CYC(POR), .SETTLE_CYC(SETTLE), .SETUP_CYC(SETUP),
    .HIGH_CYC(HIGH), .LOW_CYC(LOW), .ROW_LEN(L)
  ) uut (
    .clk(clk), .rst_n(rst_n), .lcd_db_in(db_in), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
    .lcd_en(lcd_en), .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe), .ready(ready)
  );

  initial forever #2 clk = ~clk;

  int total = 0;
  int bad = 0;

  // display model state
  logic rd_hi_next = 1'b1;
  int   busy_left = 2;
  logic busy_seen = 1'b0;
  logic last_poll_clear = 1'b0;
  logic read_half = 1'b0;
  logic wr_half = 1'b0;
  logic [3:0] wr_hi = 4'h0;
  logic wr_rs = 1'b0;
  int   wr_count = 0;

  // strobe tracking
  int   cyc = 0;
  int   pulse_n = 0;
  int   last_fall = 0;
  int   high_w = 0;
  int   ready_cyc = -1;
  logic prev_en = 1'b0;
  logic hv_rs = 1'b0, hv_rw = 1'b0;
  logic [3:0] hv_db = 4'h0;

  assign db_in = rd_hi_next ? {(busy_left != 0), 3'b101} : 4'b0110;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [8:0] want_op(input int k);
    int rem, row, pos;
    if (k == 0) return {1'b0, 8'h28};
    if (k == 1) return {1'b0, 8'h0C};
    rem = k - 2;
    row = rem / (L + 1);
    pos = rem % (L + 1);
    if (pos == 0) return {1'b0, (row == 1) ? 8'hC0 : 8'h80};
    return {1'b1, 8'h20};
  endfunction

  function automatic logic [3:0] want_raw(input int p);
    return (p == 2) ? 4'h8 : 4'h2;
  endfunction

  function automatic int next_busy(input int k);
    if (k == 0) return 0;
    if (k == 1) return 6;
    return int'($urandom_range(0, 3));
  endfunction

  // bus monitor and display model, sampled on the falling clock edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        cyc++;
        if (lcd_en) check(lcd_db_oe == !lcd_rw, "R10 oe vs rw", lcd_db_oe, !lcd_rw);
        if (lcd_en && !prev_en) begin
          if (pulse_n == 0) check(cyc >= POR, "R2 first strobe", cyc, POR);
          else if (pulse_n == 3) check(cyc - last_fall >= SETTLE, "R4 settle gap", cyc - last_fall, SETTLE);
          else check(cyc - last_fall >= LOW, "R9 low gap", cyc - last_fall, LOW);
          check(ready == 1'b0, "R8 ready low during sequence", ready, 0);
          pulse_n++;
          hv_rs = lcd_rs; hv_rw = lcd_rw; hv_db = lcd_db_out;
          high_w = 1;
        end else if (lcd_en && prev_en) begin
          high_w++;
          check(lcd_rs == hv_rs && lcd_rw == hv_rw, "R9 ctrl stable", {lcd_rs, lcd_rw}, {hv_rs, hv_rw});
          if (!hv_rw) check(lcd_db_out == hv_db, "R9 data stable", lcd_db_out, hv_db);
        end else if (!lcd_en && prev_en) begin
          last_fall = cyc;
          check(high_w == HIGH, "R9 high width", high_w, HIGH);
          check(ready == 1'b0, "R8 ready low at strobe end", ready, 0);
          if (pulse_n <= 3) begin
            check(!hv_rs && !hv_rw && hv_db == want_raw(pulse_n - 1), "R3 raw nibble",
                  {hv_rs, hv_rw, hv_db}, {2'b00, want_raw(pulse_n - 1)});
          end else if (hv_rw) begin
            check(!wr_half, "R6 read inside a write byte", wr_half, 0);
            check(!hv_rs, "R5 status read rs", hv_rs, 0);
            if (!read_half) begin
              read_half = 1'b1;
              rd_hi_next = 1'b0;
              busy_seen = (busy_left != 0);
            end else begin
              read_half = 1'b0;
              rd_hi_next = 1'b1;
              last_poll_clear = !busy_seen;
              if (busy_left > 0) busy_left--;
            end
          end else begin
            check(!read_half, "R6 write inside a status read", read_half, 0);
            if (!wr_half) begin
              check(last_poll_clear, "R5 write without clear poll", last_poll_clear, 1);
              wr_half = 1'b1;
              wr_hi = hv_db;
              wr_rs = hv_rs;
            end else begin
              wr_half = 1'b0;
              check(wr_rs == hv_rs, "R6 rs same on both halves", hv_rs, wr_rs);
              check({wr_rs, wr_hi, hv_db} == want_op(wr_count), "R7 byte order",
                    {wr_rs, wr_hi, hv_db}, want_op(wr_count));
              wr_count++;
              last_poll_clear = 1'b0;
              busy_left = next_busy(wr_count - 1);
            end
          end
        end
        if (ready && ready_cyc < 0) ready_cyc = cyc;
        prev_en = lcd_en;
      end
    end
  end

  initial begin
    int seed;
    int pulses_at_ready;
    bit timed_out;
    seed = int'($urandom(32'd20240611));
    timed_out = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state of the bus and of ready
    check(!lcd_rs && !lcd_rw && !lcd_en && lcd_db_out == 4'h0, "R1 lines low",
          {lcd_rs, lcd_rw, lcd_en, lcd_db_out}, 0);
    check(lcd_db_oe == 1'b1, "R1 bus driven", lcd_db_oe, 1);
    check(ready == 1'b0, "R1 ready low", ready, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 100000 && !ready; i++) @(negedge clk);
    if (!ready) begin
      timed_out = 1'b1;
      check(1'b0, "watchdog R8 ready never rose", 0, 1);
    end
    if (!timed_out) begin
      check(wr_count == NOPS, "R7 byte count", wr_count, NOPS);
      check(ready_cyc - last_fall <= LOW + 4, "R8 ready latency", ready_cyc - last_fall, LOW + 4);
      pulses_at_ready = pulse_n;
      for (int i = 0; i < 80; i++) begin
        @(negedge clk);
        if (!ready || lcd_en) begin
          check(1'b0, "R8 ready held and bus quiet", {ready, lcd_en}, 2'b10);
          break;
        end
      end
      check(pulse_n == pulses_at_ready, "R8 no strobe after ready", pulse_n, pulses_at_ready);
      check(ready == 1'b1, "R8 ready sticky", ready, 1);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule